// File: doc/BRIEF.md
# Receive FIFO with Burst-Ready and Idle-Timeout Events

This block buffers received characters in a byte-wide FIFO and tells the consumer when it is worth reading. A burst-ready event means the FIFO holds at least one full read burst, so the reader can take that many bytes without checking any status. A timeout event covers the leftover data: some bytes are waiting, fewer than a burst, and no character has arrived for a set number of character times. The reader can then drain the tail.

The read burst size is set by a 4-bit word field and a 2-bit leftover-byte field. With byte granularity on, the size is four times the word field plus the leftover bytes. With it off, the size is four times the word field and the leftover field is ignored. The burst fields may change at any time, and the burst-ready output follows them in the same cycle. A deserializer pushes characters on a valid/ready port. A consumer pops on a second valid/ready port. A clear command empties the FIFO.

Back-pressure rules. On the push side, `in_ready` is low while the FIFO is full, but the producer is not obliged to wait. A character offered while the FIFO is full is dropped and recorded in a sticky overrun flag. On the pop side, `out_valid` is high whenever a byte is stored, and a byte leaves on any cycle where `out_valid` and `out_ready` are both high. `out_data` stays stable until that happens.

Top module: `rx_burst_fifo`

## Requirements
- R1: The FIFO holds DEPTH bytes (64 by default). `level` always shows the number of stored bytes, from 0 to DEPTH. `in_ready` is high exactly when `level` is below DEPTH.
- R2: Bytes leave in arrival order. `out_valid` is high exactly when `level` is nonzero, `out_data` shows the oldest byte, and a pop happens on a cycle with `out_valid` and `out_ready` both high.
- R3: The burst size is 4*`burst_words`+`burst_bytes` when `byte_gran`=1, and 4*`burst_words` when `byte_gran`=0. `evt_burst` is high exactly when the burst size is nonzero and `level` is at least the burst size. A zero burst size never raises `evt_burst`.
- R4: A change to `burst_words`, `burst_bytes` or `byte_gran` shows on `evt_burst` in the same cycle, with no clock edge needed.
- R5: An idle counter advances on each rising edge where `char_tick` is high, the FIFO is non-empty, and no push or pop is offered. After TMO_CHARS such ticks (4 by default), the timeout condition becomes true. Any `in_valid` strobe and any pop restart the count from zero.
- R6: The timeout condition clears on an `in_valid` strobe and when the FIFO drains to empty. A pop that leaves data behind keeps the condition but restarts the count.
- R7: When both conditions hold, burst-ready wins: `evt_timeout` is the timeout condition masked by `evt_burst`, and the two outputs are never high together.
- R8: An `in_valid` strobe while the FIFO is full is discarded. The stored bytes and `level` stay unchanged, and `overrun` goes high and stays high.
- R9: `clear` empties the FIFO and resets `overrun`, the idle counter and the timeout condition. It overrides any push or pop offered in the same cycle.
- R10: A push and a pop in the same cycle, with the FIFO neither empty nor full, leave `level` unchanged and keep the order of the bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Character-done strobe from the deserializer |
| in_ready | output | 1 | FIFO has room |
| in_data | input | DATA_W | Received character |
| out_valid | output | 1 | FIFO holds at least one byte |
| out_ready | input | 1 | Consumer takes `out_data` |
| out_data | output | DATA_W | Oldest stored byte |
| char_tick | input | 1 | One pulse per character time |
| clear | input | 1 | Empty the FIFO and clear status |
| burst_words | input | 4 | Read burst size in 4-byte words |
| burst_bytes | input | 2 | Extra bytes of the burst size (byte granularity only) |
| byte_gran | input | 1 | 1 adds `burst_bytes` to the burst size |
| level | output | LVL_W | Stored byte count |
| evt_burst | output | 1 | At least one full burst is readable |
| evt_timeout | output | 1 | Partial burst left idle |
| overrun | output | 1 | Sticky: a character was dropped |

## Verification
The bench builds the block with DEPTH=16 and TMO_CHARS=3. With these values, full, overrun and wrap-around are reached after a handful of pushes. At every fill level from empty to full, the bench applies all 128 combinations of word field, leftover field and granularity bit. This covers zero bursts, bursts equal to the level, and bursts larger than the FIFO, which can never fire. The short idle window lets the bench check the tick just before and the tick at expiry, after each kind of counter restart.

// File: rtl/rx_burst_pkg.sv
package rx_burst_pkg;
  localparam int WORDS_W = 4;
  localparam int BYTES_W = 2;
  localparam int BURST_W = WORDS_W + BYTES_W;

  function automatic logic [BURST_W-1:0] burst_size(
    input logic [WORDS_W-1:0] words,
    input logic [BYTES_W-1:0] bytes,
    input logic               gran
  );
    logic [BURST_W-1:0] base;
    base = {words, {BYTES_W{1'b0}}};
    return gran ? (base | {{WORDS_W{1'b0}}, bytes}) : base;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  level
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/rxq_burst_cmp.sv
module rxq_burst_cmp
  import rx_burst_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic [LVL_W-1:0]   level,
  input  logic [WORDS_W-1:0] words,
  input  logic [BYTES_W-1:0] bytes,
  input  logic               gran,
  output logic               ready
);
  logic [BURST_W-1:0] size;
  logic [31:0]        lvl_ext, size_ext;

  always_comb begin
    size     = burst_size(words, bytes, gran);
    lvl_ext  = 32'(level);
    size_ext = 32'(size);
    ready    = (size != '0) && (lvl_ext >= size_ext);
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TMO_CHARS = 4,
  parameter int LVL_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             char_in,
  input  logic             pop,
  input  logic             push,
  input  logic             tick,
  input  logic [LVL_W-1:0] level,
  output logic             expired
);
  localparam int CNT_W = $clog2(TMO_CHARS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_CHARS);

  logic [CNT_W-1:0] cnt;
  logic             drain;

  assign drain = pop && !push && (level == LVL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (clear || char_in || drain) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (pop) begin
      cnt <= '0;
    end else if (tick && (level != '0) && (cnt != LIMIT)) begin
      cnt <= cnt + 1'b1;
      if (cnt + 1'b1 == LIMIT) expired <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_burst_fifo.sv
module rx_burst_fifo
  import rx_burst_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 8,
  parameter int TMO_CHARS = 4,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              char_tick,
  input  logic              clear,
  input  logic [3:0]        burst_words,
  input  logic [1:0]        burst_bytes,
  input  logic              byte_gran,
  output logic [LVL_W-1:0]  level,
  output logic              evt_burst,
  output logic              evt_timeout,
  output logic              overrun
);
  logic push_acc, pop_acc, tmo_raw;

  assign in_ready  = (level != LVL_W'(DEPTH));
  assign out_valid = (level != '0);
  assign push_acc  = in_valid && in_ready && !clear;
  assign pop_acc   = out_valid && out_ready && !clear;

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(clear), .push(push_acc), .pop(pop_acc),
    .wdata(in_data), .rdata(out_data), .level(level)
  );

  rxq_burst_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level(level), .words(burst_words), .bytes(burst_bytes),
    .gran(byte_gran), .ready(evt_burst)
  );

  rxq_idle_timer #(.TMO_CHARS(TMO_CHARS), .LVL_W(LVL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(clear), .char_in(in_valid),
    .pop(pop_acc), .push(push_acc), .tick(char_tick), .level(level),
    .expired(tmo_raw)
  );

  assign evt_timeout = tmo_raw && !evt_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     overrun <= 1'b0;
    else if (clear)                 overrun <= 1'b0;
    else if (in_valid && !in_ready) overrun <= 1'b1;
  end
endmodule

// File: rtl/rx_burst_fifo_chk.sv
module rx_burst_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             clear,
  input logic [LVL_W-1:0] level,
  input logic             evt_burst,
  input logic             evt_timeout,
  input logic             overrun
);
  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH)) |-> !in_ready);

  p_valid_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (level != '0));

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_ready && !clear) |=> level == $past(level) + 1'b1);

  p_events_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_burst && evt_timeout));

  p_no_timeout_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !evt_timeout);

  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_ready && !clear) |=> (overrun && $stable(level)));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clear) |=> overrun);

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (level == '0 && !overrun && !evt_timeout));

  p_balanced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready && !clear) |=> $stable(level));
endmodule

bind rx_burst_fifo rx_burst_fifo_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .clear(clear), .level(level),
  .evt_burst(evt_burst), .evt_timeout(evt_timeout), .overrun(overrun)
);

// File: tb/test_rx_burst_fifo.sv
module test_rx_burst_fifo;
  localparam int DEPTH = 16;
  localparam int TMO   = 3;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, char_tick = 1'b0, clear = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] burst_words = '0;
  logic [1:0] burst_bytes = '0;
  logic byte_gran = 1'b0;
  logic in_ready, out_valid, evt_burst, evt_timeout, overrun;
  logic [7:0] out_data;
  logic [LVL_W-1:0] level;

  int vecs = 0, errs = 0;
  bit done = 0;
  logic [7:0] mq[$];

  always #4 clk = ~clk;

  rx_burst_fifo #(.DEPTH(DEPTH), .DATA_W(8), .TMO_CHARS(TMO)) i_rx_burst_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .char_tick(char_tick), .clear(clear),
    .burst_words(burst_words), .burst_bytes(burst_bytes), .byte_gran(byte_gran),
    .level(level), .evt_burst(evt_burst), .evt_timeout(evt_timeout),
    .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    @(negedge clk); in_valid = 1'b0;
    if (mq.size() < DEPTH) mq.push_back(d);
  endtask

  task automatic pop();
    @(negedge clk);
    check("R2 data order", out_data, mq[0]);
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    void'(mq.pop_front());
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); char_tick = 1'b1;
      @(negedge clk); char_tick = 1'b0;
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    mq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int exp_b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 reset state
    check("R1 reset level", level, 0);
    check("R1 reset in_ready", in_ready, 1);
    check("R2 reset out_valid", out_valid, 0);
    check("R8 reset overrun", overrun, 0);

    // R3 R4 sweep of burst configs at every level
    for (int l = 0; l <= DEPTH; l++) begin
      for (int g = 0; g < 2; g++)
        for (int w = 0; w < 16; w++)
          for (int b = 0; b < 4; b++) begin
            byte_gran = g[0]; burst_words = w[3:0]; burst_bytes = b[1:0];
            #1;
            exp_b = g ? 4*w + b : 4*w;
            check("R3 R4 burst threshold", evt_burst, (exp_b != 0 && l >= exp_b) ? 1 : 0);
            check("R7 no timeout", evt_timeout, 0);
          end
      check("R1 level", level, l);
      check("R1 in_ready", in_ready, (l < DEPTH) ? 1 : 0);
      check("R2 out_valid", out_valid, (l > 0) ? 1 : 0);
      if (l < DEPTH) push(8'((l * 37 + 5)));
    end

    // R8 overrun at full
    push(8'hEE);
    check("R8 level held", level, DEPTH);
    check("R8 overrun set", overrun, 1);
    // drain, checking order and that dropped byte is absent
    for (int i = 0; i < DEPTH; i++) pop();
    check("R2 empty after drain", out_valid, 0);
    check("R8 overrun sticky", overrun, 1);
    do_clear();
    check("R9 overrun cleared", overrun, 0);

    // R10 simultaneous push and pop
    push(8'h11); push(8'h22);
    @(negedge clk);
    check("R10 head before", out_data, 8'h11);
    in_valid = 1'b1; in_data = 8'h33; out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b0;
    void'(mq.pop_front()); mq.push_back(8'h33);
    check("R10 level kept", level, 2);
    pop(); pop();

    // R9 clear beats push
    push(8'h44);
    @(negedge clk); clear = 1'b1; in_valid = 1'b1; in_data = 8'h55; out_ready = 1'b1;
    @(negedge clk); clear = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    mq.delete();
    check("R9 clear wins", level, 0);

    // R5 timeout, burst of 8 words-only
    byte_gran = 1'b0; burst_words = 4'd2; burst_bytes = 2'd3;
    push(8'h01); push(8'h02); push(8'h03);
    ticks(TMO - 1);
    check("R5 not yet", evt_timeout, 0);
    ticks(1);
    check("R5 expired", evt_timeout, 1);
    check("R3 no burst", evt_burst, 0);
    // R7 priority, R4 live change
    byte_gran = 1'b1; burst_words = 4'd0; burst_bytes = 2'd2; #1;
    check("R7 burst wins", evt_burst, 1);
    check("R7 timeout masked", evt_timeout, 0);
    byte_gran = 1'b0; burst_words = 4'd2; #1;
    check("R7 timeout back", evt_timeout, 1);
    // R6 new character clears
    push(8'h04);
    check("R6 char clears", evt_timeout, 0);
    // R5 pop restarts count
    ticks(TMO - 1);
    pop();
    ticks(TMO - 1);
    check("R5 pop restarts", evt_timeout, 0);
    ticks(1);
    check("R5 expired after pop", evt_timeout, 1);
    pop();
    check("R6 partial pop keeps", evt_timeout, 1);
    pop(); pop();
    check("R6 empty clears", evt_timeout, 0);
    ticks(TMO + 2);
    check("R5 empty no count", evt_timeout, 0);
    push(8'h09);
    ticks(TMO - 1);
    check("R5 fresh window", evt_timeout, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule